// File: doc/BRIEF.md
# Bus Transceiver Power-Mode Controller

This block sequences the operating modes of a single-wire automotive bus transceiver. It has four named states: OFF (no supply), STANDBY, ACTIVE (full communication) and SLEEP. It reacts to a power-on-reset flag, to an enable input sampled on the system clock, and to a wake-up pulse from an external detector. The pulse is already validated and carries a tag that says whether the wake came from the bus or from a local switch. The block then drives the control lines of the analog front end:

- the transmitter enable;
- the switch that feeds an external regulator;
- the bus termination choice;
- the drive mode of the receive pin;
- the strength of the transmit-pin pull-down.

The named transitions are:

- power-up: OFF to STANDBY;
- go-active: STANDBY or SLEEP to ACTIVE, through the enable filter;
- go-sleep: ACTIVE to SLEEP, through the disable filter;
- wake: SLEEP to STANDBY, or ACTIVE to STANDBY while the disable filter is counting;
- power-loss: any state to OFF.

Filter times are counted in clock cycles (`EN_CYC`, `DIS_CYC`).

The standby pin settings record how STANDBY was entered. The first sampled high on the enable input drops that record, well before the enable filter finishes, so that the standby pin settings cannot clash with the levels the controller drives for normal traffic.

Top module: `bus_power_mode_ctrl`

## Requirements
- R1: While `por_i` is high the block is in OFF at once, without waiting for a clock edge. In OFF, `xcvr_en_o`=0, `inh_on_o`=0, `term_sel_o`=00 (floating), `rx_mode_o`=00 (high-impedance) and `txpd_strong_o`=0.
- R2: On the first clock edge after `por_i` falls, the block enters STANDBY with the power-up origin. Its outputs are then `inh_on_o`=1, `term_sel_o`=01 (resistor), `rx_mode_o`=00, `txpd_strong_o`=0 and `xcvr_en_o`=0.
- R3: From STANDBY or SLEEP, the block enters ACTIVE on the `EN_CYC`-th consecutive clock edge that samples `en_i` high, and not before. In ACTIVE, `xcvr_en_o`=1, `inh_on_o`=1, `term_sel_o`=01, `rx_mode_o`=10 and `txpd_strong_o`=0.
- R4: If a sample of `en_i` breaks a run, the run count clears and the state does not change. A later run must again last the full filter length.
- R5: From ACTIVE, the block enters SLEEP on the `DIS_CYC`-th consecutive edge that samples `en_i` low. In SLEEP, `inh_on_o`=0, `term_sel_o`=10 (weak current source), `rx_mode_o`=00 and `xcvr_en_o`=0.
- R6: A `wake_valid_i` pulse in SLEEP moves the block to STANDBY on that edge, and `rx_mode_o` becomes 01 (driven low). `txpd_strong_o` is 1 when `wake_local_i`=1 (local wake) and 0 when `wake_local_i`=0 (bus wake). A wake beats an enable-filter expiry on the same edge.
- R7: In ACTIVE, a wake pulse taken while `en_i` is low (disable filter counting) leads to STANDBY with the origin set by the tag. A wake pulse taken while `en_i` is high is ignored.
- R8: Wake pulses taken in STANDBY leave `rx_mode_o` and `txpd_strong_o` unchanged.
- R9: In STANDBY, the first edge that samples `en_i` high sets `rx_mode_o`=00 and `txpd_strong_o`=0 while the block is still in STANDBY. These settings stay in place if `en_i` falls again before the filter expires.
- R10: Only ACTIVE sets `xcvr_en_o`. In ACTIVE, `rx_data_o` follows `bus_rx_i` combinationally. Elsewhere `rx_data_o` is 0 when `rx_mode_o`=01 and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on-reset flag, active high, asynchronous |
| en_i | input | 1 | Mode enable from the controller |
| wake_valid_i | input | 1 | One-cycle pulse for a validated wake-up |
| wake_local_i | input | 1 | Wake tag: 1 local switch, 0 bus |
| bus_rx_i | input | 1 | Received bus level from the comparator |
| xcvr_en_o | output | 1 | Transmitter/receiver enable |
| inh_on_o | output | 1 | Regulator-inhibit switch on |
| term_sel_o | output | 2 | Termination: 00 floating, 01 resistor, 10 current source |
| rx_mode_o | output | 2 | Receive pin: 00 high-Z, 01 driven low, 10 data |
| rx_data_o | output | 1 | Level for the receive pin |
| txpd_strong_o | output | 1 | Transmit pull-down: 1 strong, 0 weak |

## Verification
The hardest case to reach is a wake pulse that lands inside the disable-filter window of ACTIVE. The stimulus first steps the block through a full go-active sequence. It then holds `en_i` low for fewer than `DIS_CYC` edges and fires a local wake, which must end in STANDBY with a strong pull-down instead of SLEEP. Another case is the enable-filter restart, which needs a run one edge short of the limit, one break sample, and then an exact count to the transition edge. A third is the standby release, which must show released pins while the block still reports STANDBY, and must keep them after `en_i` falls back.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PM_OFF     = 2'd0,
        PM_STANDBY = 2'd1,
        PM_ACTIVE  = 2'd2,
        PM_SLEEP   = 2'd3
    } pm_state_e;

    typedef enum logic [1:0] {
        ORIGIN_POWERUP   = 2'd0,
        ORIGIN_BUSWAKE   = 2'd1,
        ORIGIN_LOCALWAKE = 2'd2
    } stby_origin_e;

    localparam logic [1:0] TERM_FLOAT = 2'b00;
    localparam logic [1:0] TERM_RES   = 2'b01;
    localparam logic [1:0] TERM_CSRC  = 2'b10;

    localparam logic [1:0] RXM_HIZ  = 2'b00;
    localparam logic [1:0] RXM_LOW  = 2'b01;
    localparam logic [1:0] RXM_DATA = 2'b10;

endpackage

// File: rtl/pm_level_filter.sv
module pm_level_filter #(
    parameter int LIMIT = 8,
    parameter bit LEVEL = 1'b1
) (
    input  logic clk,
    input  logic por_i,
    input  logic arm_i,
    input  logic sig_i,
    output logic run_o,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          match;

    assign match = arm_i && (sig_i == LEVEL);

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            cnt_q <= '0;
        end else if (!match) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign run_o = match;
    assign hit_o = match && (cnt_q == CW'(LIMIT - 1));

    // R4: a broken run leaves the count at zero
    a_r4_count_clears: assert property (@(posedge clk) disable iff (por_i)
        !match |=> (cnt_q == '0));

endmodule

// File: rtl/pm_pin_decode.sv
module pm_pin_decode
    import pm_pkg::*;
(
    input  pm_state_e    state_i,
    input  stby_origin_e origin_i,
    input  logic         bus_rx_i,
    output logic         xcvr_en_o,
    output logic         inh_on_o,
    output logic [1:0]   term_sel_o,
    output logic [1:0]   rx_mode_o,
    output logic         rx_data_o,
    output logic         txpd_strong_o
);
    always_comb begin
        xcvr_en_o     = 1'b0;
        inh_on_o      = 1'b0;
        term_sel_o    = TERM_FLOAT;
        rx_mode_o     = RXM_HIZ;
        txpd_strong_o = 1'b0;
        unique case (state_i)
            PM_OFF: begin
            end
            PM_STANDBY: begin
                inh_on_o      = 1'b1;
                term_sel_o    = TERM_RES;
                rx_mode_o     = (origin_i == ORIGIN_POWERUP) ? RXM_HIZ : RXM_LOW;
                txpd_strong_o = (origin_i == ORIGIN_LOCALWAKE);
            end
            PM_ACTIVE: begin
                xcvr_en_o  = 1'b1;
                inh_on_o   = 1'b1;
                term_sel_o = TERM_RES;
                rx_mode_o  = RXM_DATA;
            end
            PM_SLEEP: begin
                term_sel_o = TERM_CSRC;
            end
        endcase
    end

    always_comb begin
        unique case (rx_mode_o)
            RXM_DATA: rx_data_o = bus_rx_i;
            RXM_LOW:  rx_data_o = 1'b0;
            default:  rx_data_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/bus_power_mode_ctrl.sv
module bus_power_mode_ctrl
    import pm_pkg::*;
#(
    parameter int EN_CYC  = 8,
    parameter int DIS_CYC = 12
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       en_i,
    input  logic       wake_valid_i,
    input  logic       wake_local_i,
    input  logic       bus_rx_i,
    output logic       xcvr_en_o,
    output logic       inh_on_o,
    output logic [1:0] term_sel_o,
    output logic [1:0] rx_mode_o,
    output logic       rx_data_o,
    output logic       txpd_strong_o
);
    pm_state_e    state_q, state_d;
    stby_origin_e origin_q, origin_d, wake_origin;
    logic         en_arm, en_run, en_hit;
    logic         dis_arm, dis_run, dis_hit;

    assign en_arm      = (state_q == PM_STANDBY) || (state_q == PM_SLEEP);
    assign dis_arm     = (state_q == PM_ACTIVE);
    assign wake_origin = wake_local_i ? ORIGIN_LOCALWAKE : ORIGIN_BUSWAKE;

    pm_level_filter #(.LIMIT(EN_CYC), .LEVEL(1'b1)) u_en_filt (
        .clk   (clk),
        .por_i (por_i),
        .arm_i (en_arm),
        .sig_i (en_i),
        .run_o (en_run),
        .hit_o (en_hit)
    );

    pm_level_filter #(.LIMIT(DIS_CYC), .LEVEL(1'b0)) u_dis_filt (
        .clk   (clk),
        .por_i (por_i),
        .arm_i (dis_arm),
        .sig_i (en_i),
        .run_o (dis_run),
        .hit_o (dis_hit)
    );

    always_comb begin
        state_d  = state_q;
        origin_d = origin_q;
        unique case (state_q)
            PM_OFF: begin
                state_d  = PM_STANDBY;
                origin_d = ORIGIN_POWERUP;
            end
            PM_STANDBY: begin
                if (en_run) origin_d = ORIGIN_POWERUP;
                if (en_hit) state_d = PM_ACTIVE;
            end
            PM_ACTIVE: begin
                if (dis_run && wake_valid_i) begin
                    state_d  = PM_STANDBY;
                    origin_d = wake_origin;
                end else if (dis_hit) begin
                    state_d = PM_SLEEP;
                end
            end
            PM_SLEEP: begin
                if (wake_valid_i) begin
                    state_d  = PM_STANDBY;
                    origin_d = wake_origin;
                end else if (en_hit) begin
                    state_d = PM_ACTIVE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            state_q  <= PM_OFF;
            origin_q <= ORIGIN_POWERUP;
        end else begin
            state_q  <= state_d;
            origin_q <= origin_d;
        end
    end

    pm_pin_decode u_pins (
        .state_i       (state_q),
        .origin_i      (origin_q),
        .bus_rx_i      (bus_rx_i),
        .xcvr_en_o     (xcvr_en_o),
        .inh_on_o      (inh_on_o),
        .term_sel_o    (term_sel_o),
        .rx_mode_o     (rx_mode_o),
        .rx_data_o     (rx_data_o),
        .txpd_strong_o (txpd_strong_o)
    );

    a_r3_no_entry_without_en: assert property (@(posedge clk) disable iff (por_i)
        (state_q != PM_ACTIVE && !en_i) |=> (state_q != PM_ACTIVE));

    a_r5_hold_active_with_en: assert property (@(posedge clk) disable iff (por_i)
        (state_q == PM_ACTIVE && en_i) |=> (state_q == PM_ACTIVE));

    a_r6_wake_leaves_sleep: assert property (@(posedge clk) disable iff (por_i)
        (state_q == PM_SLEEP && wake_valid_i) |=> (state_q == PM_STANDBY));

    a_r8_standby_pins_hold: assert property (@(posedge clk) disable iff (por_i)
        (state_q == PM_STANDBY && !en_i) |=>
            (state_q == PM_STANDBY && $stable(rx_mode_o) && $stable(txpd_strong_o)));

    a_r10_xcvr_only_active: assert property (@(posedge clk) disable iff (por_i)
        xcvr_en_o |-> (state_q == PM_ACTIVE && inh_on_o));

endmodule

// File: tb/test_bus_power_mode_ctrl.sv
module test_bus_power_mode_ctrl;
    localparam int EN_CYC  = 8;
    localparam int DIS_CYC = 12;

    logic clk = 1'b0;
    logic por, en, wake, wloc, brx;
    logic xcvr, inh, rxd, pd;
    logic [1:0] term, rxm;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bus_power_mode_ctrl #(.EN_CYC(EN_CYC), .DIS_CYC(DIS_CYC)) i_bus_power_mode_ctrl (
        .clk (clk), .por_i (por), .en_i (en), .wake_valid_i (wake),
        .wake_local_i (wloc), .bus_rx_i (brx), .xcvr_en_o (xcvr),
        .inh_on_o (inh), .term_sel_o (term), .rx_mode_o (rxm),
        .rx_data_o (rxd), .txpd_strong_o (pd)
    );

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, name, act, exp);
        end
    endtask

    task automatic pins(input string tag, input int x, input int ih, input int tm,
                        input int rm, input int p);
        chk(tag, "xcvr_en", int'(xcvr), x);
        chk(tag, "inh_on", int'(inh), ih);
        chk(tag, "term_sel", int'(term), tm);
        chk(tag, "rx_mode", int'(rxm), rm);
        chk(tag, "txpd_strong", int'(pd), p);
    endtask

    task automatic pulse_wake(input logic local_tag);
        wloc = local_tag;
        wake = 1'b1;
        tick(1);
        wake = 1'b0;
    endtask

    task automatic t_power_up();
        por = 1'b1; en = 1'b0; wake = 1'b0; wloc = 1'b0; brx = 1'b1;
        tick(3);
        pins("R1", 0, 0, 0, 0, 0);
        por = 1'b0;
        tick(1);
        pins("R2", 0, 1, 1, 0, 0);
        chk("R10", "rx_data", int'(rxd), 1);
    endtask

    task automatic t_enable_restart();
        en = 1'b1;
        tick(EN_CYC - 1);
        chk("R4", "xcvr_en", int'(xcvr), 0);
        en = 1'b0;
        tick(1);
        en = 1'b1;
        tick(EN_CYC - 1);
        chk("R4", "xcvr_en", int'(xcvr), 0);
        tick(1);
        pins("R3", 1, 1, 1, 2, 0);
    endtask

    task automatic t_rx_follow();
        brx = 1'b0;
        #1;
        chk("R10", "rx_data", int'(rxd), 0);
        brx = 1'b1;
        #1;
        chk("R10", "rx_data", int'(rxd), 1);
    endtask

    task automatic t_go_sleep();
        en = 1'b0;
        tick(DIS_CYC - 1);
        chk("R5", "xcvr_en", int'(xcvr), 1);
        tick(1);
        pins("R5", 0, 0, 2, 0, 0);
        chk("R5", "rx_data", int'(rxd), 1);
    endtask

    task automatic t_sleep_to_active();
        en = 1'b1;
        tick(EN_CYC - 1);
        chk("R3", "inh_on", int'(inh), 0);
        tick(1);
        pins("R3", 1, 1, 1, 2, 0);
    endtask

    task automatic t_local_wake_release();
        pulse_wake(1'b1);
        pins("R6", 0, 1, 1, 1, 1);
        chk("R10", "rx_data", int'(rxd), 0);
        pulse_wake(1'b0);
        tick(2);
        chk("R8", "rx_mode", int'(rxm), 1);
        chk("R8", "txpd_strong", int'(pd), 1);
        en = 1'b1;
        tick(1);
        pins("R9", 0, 1, 1, 0, 0);
        en = 1'b0;
        tick(2);
        pins("R9", 0, 1, 1, 0, 0);
        en = 1'b1;
        tick(EN_CYC);
        chk("R3", "xcvr_en", int'(xcvr), 1);
    endtask

    task automatic t_bus_wake_and_priority();
        en = 1'b0;
        tick(DIS_CYC);
        chk("R5", "term_sel", int'(term), 2);
        en = 1'b1;
        tick(EN_CYC - 1);
        pulse_wake(1'b0);
        pins("R6", 0, 1, 1, 1, 0);
        en = 1'b0;
        tick(1);
        en = 1'b1;
        tick(EN_CYC);
        chk("R3", "xcvr_en", int'(xcvr), 1);
    endtask

    task automatic t_wake_in_active();
        pulse_wake(1'b1);
        chk("R7", "xcvr_en", int'(xcvr), 1);
        en = 1'b0;
        tick(3);
        pulse_wake(1'b1);
        pins("R7", 0, 1, 1, 1, 1);
    endtask

    task automatic t_power_loss();
        en = 1'b1;
        tick(EN_CYC);
        chk("R3", "xcvr_en", int'(xcvr), 1);
        por = 1'b1;
        #1;
        pins("R1", 0, 0, 0, 0, 0);
        tick(2);
        por = 1'b0;
        en = 1'b0;
        tick(1);
        pins("R2", 0, 1, 1, 0, 0);
    endtask

    initial begin
        t_power_up();
        t_enable_restart();
        t_rx_follow();
        t_go_sleep();
        t_sleep_to_active();
        en = 1'b0;
        tick(DIS_CYC);
        t_local_wake_release();
        t_bus_wake_and_priority();
        t_wake_in_active();
        t_power_loss();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule